// File: doc/BRIEF.md
# Per-Core Private Interrupt Register Bank

This block holds the programmable state of the 32 private interrupts of one core: 16 software-generated interrupts (numbers 0 to 15) and 16 peripheral interrupts (numbers 16 to 31). It covers their group, group-modifier, enable, pending, active, priority and trigger-configuration bits. It also holds the non-secure access field, a sleep handshake register, a control register and two 64-bit table base registers. A simple register bus reaches it. Each request carries a 12-bit byte offset, a size code and a secure/non-secure attribute. A read returns its data one cycle later.

Each access is filtered by the caller's security state. When security is enabled (`sec_disable` low), a non-secure caller reaches only the interrupts marked group 1 in the group register. It sees their priorities in a rescaled form, not the stored values. Enable, pending and active bits use paired set and clear addresses. A one-cycle update pulse tells the downstream priority logic that interrupt state has changed. A rescan request pulse tells the table walker to re-examine its tables.

Top module: `prv_irq_regs`

## Requirements
- R1: After reset the following values hold: group, group-modifier, enable, pending, active, non-secure access, wake, control, table bases and all priorities read 0; the trigger bits of interrupts 0-15 are 1 (edge) and those of 16-31 are 0 (level); `rsp_valid`, `update_pulse` and `rescan_req` are low.
- R2: A write to a set address ORs the access-masked value into its register. A write to a clear address ANDs out the masked value. Both addresses read the same register. The address pairs are enable 0x100/0x180, pending 0x200/0x280 and active 0x300/0x380.
- R3: The access mask is the group register (0x080) when `req_secure`=0 and `sec_disable`=0, and all ones otherwise. Masked-out bits read 0 and ignore writes.
- R4: Priorities are 8-bit fields at 0x400+n. For a non-secure access with security enabled, the field of a group-0 interrupt reads 0 and ignores writes. For a group-1 interrupt, a write of v stores 0x80|(v>>1), and a read returns (stored<<1)&0xFF. Other accesses store and return raw values.
- R5: A word access (size 1) to the priority range covers fields n..n+3, with the lowest field in bits 7:0. A byte access (size 0) covers one field.
- R6: A read of the pending register returns the pending latch ORed with `irq_level` for the level-triggered interrupts, then masked.
- R7: Trigger bits read through 0xC00 (interrupts 0-15) and 0xC04 (16-31), with interrupt k's bit at word bit 2*(k mod 16)+1 and all even bits 0. Writes to 0xC00 are ignored. A write to 0xC04 takes its odd bits into interrupts 16-31, limited by the access mask.
- R8: The group register reads 0 and ignores writes for a non-secure access with security enabled. The group-modifier (0xD00) and non-secure access (0xE00) registers are usable only for a secure access with security enabled, and otherwise read 0 and ignore writes.
- R9: In the wake register (0x014) only bit 1 (sleep request) is writable. Bit 2 (asleep) reads equal to bit 1, and the other bits read 0.
- R10: Unmapped offsets, size code 3, byte access outside the priority range and misaligned accesses read 0 and ignore writes. The identification (0x004) and type (0x008, 64-bit) registers are read-only.
- R11: The property base (0x070) and pending base (0x078) registers take 32-bit half writes at +0/+4 or a 64-bit write (size 2) at +0. In control (0x000) only bit 0 is writable, and writing it as 1 raises `rescan_req` for one cycle.
- R12: `update_pulse` is high for one cycle after a write that changes the group, enable, pending, active, priority or trigger state. It stays low after any other write.
- R13: A read request gives `rsp_valid` high in the next cycle with the data in `rsp_rdata`. Word reads have bits 63:32 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Global security disable |
| irq_level | input | 32 | Current input level of each private interrupt line |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 unsupported |
| req_secure | input | 1 | Secure attribute of the request |
| req_addr | input | 12 | Byte offset within the bank |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| update_pulse | output | 1 | Interrupt state changed by the last write |
| rescan_req | output | 1 | Table rescan requested |

## Verification
The bank is tested with the same registers reached three ways: secure, non-secure with security enabled, and non-secure with security disabled. A wrong access mask, a missing priority rescale or a leaky secure-only register each shows up as a different result. Set and clear writes are applied over bits that are already set, so that a clear implemented as a plain write is caught. The same writes also show that `update_pulse` follows real changes and not every write. Pending reads are repeated after trigger bits flip, which separates the latch from the line level. Misaligned, unsupported-size and read-only accesses are mixed in to expose decode holes.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;

    localparam int NIRQ   = 32;
    localparam int PRIO_W = 8;
    localparam int OFFS_W = 12;
    localparam int IDX_W  = $clog2(NIRQ);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_CTRL, SEL_IDENT, SEL_TYPE_LO, SEL_TYPE_HI, SEL_TYPE64,
        SEL_WAKE, SEL_PROP_LO, SEL_PROP_HI, SEL_PROP64, SEL_PNDB_LO,
        SEL_PNDB_HI, SEL_PNDB64, SEL_GROUP, SEL_SEN, SEL_CEN, SEL_SPEND,
        SEL_CPEND, SEL_SACT, SEL_CACT, SEL_PRIO, SEL_CFG0, SEL_CFG1,
        SEL_GMOD, SEL_NSAC
    } reg_sel_e;

    localparam logic [OFFS_W-1:0] OFF_CTRL  = 12'h000;
    localparam logic [OFFS_W-1:0] OFF_IDENT = 12'h004;
    localparam logic [OFFS_W-1:0] OFF_TYPE  = 12'h008;
    localparam logic [OFFS_W-1:0] OFF_WAKE  = 12'h014;
    localparam logic [OFFS_W-1:0] OFF_PROP  = 12'h070;
    localparam logic [OFFS_W-1:0] OFF_PNDB  = 12'h078;
    localparam logic [OFFS_W-1:0] OFF_GROUP = 12'h080;
    localparam logic [OFFS_W-1:0] OFF_SEN   = 12'h100;
    localparam logic [OFFS_W-1:0] OFF_CEN   = 12'h180;
    localparam logic [OFFS_W-1:0] OFF_SPEND = 12'h200;
    localparam logic [OFFS_W-1:0] OFF_CPEND = 12'h280;
    localparam logic [OFFS_W-1:0] OFF_SACT  = 12'h300;
    localparam logic [OFFS_W-1:0] OFF_CACT  = 12'h380;
    localparam logic [OFFS_W-1:0] OFF_PRIO  = 12'h400;
    localparam logic [OFFS_W-1:0] OFF_CFG0  = 12'hC00;
    localparam logic [OFFS_W-1:0] OFF_CFG1  = 12'hC04;
    localparam logic [OFFS_W-1:0] OFF_GMOD  = 12'hD00;
    localparam logic [OFFS_W-1:0] OFF_NSAC  = 12'hE00;

    // Interrupts 0..15 are always edge triggered after reset.
    localparam logic [NIRQ-1:0] EDGE_RESET = 32'h0000_FFFF;

    // Place 16 trigger bits on the odd positions of a word.
    function automatic logic [31:0] cfg_spread(input logic [15:0] v);
        logic [31:0] o;
        o = '0;
        for (int i = 0; i < 16; i++) o[2*i+1] = v[i];
        return o;
    endfunction

    // Collect the odd positions of a word into 16 trigger bits.
    function automatic logic [15:0] cfg_compact(input logic [31:0] w);
        logic [15:0] o;
        for (int i = 0; i < 16; i++) o[i] = w[2*i+1];
        return o;
    endfunction

    function automatic logic [PRIO_W-1:0] prio_ns_store(input logic [PRIO_W-1:0] v);
        return {1'b1, v[PRIO_W-1:1]};
    endfunction

    function automatic logic [PRIO_W-1:0] prio_ns_view(input logic [PRIO_W-1:0] p);
        return {p[PRIO_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/prv_irq_decode.sv
module prv_irq_decode
    import prv_irq_pkg::*;
(
    input  logic [OFFS_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_sel_e          sel
);
    logic aligned;
    logic in_prio;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE:  aligned = 1'b1;
            SZ_WORD:  aligned = (addr[1:0] == 2'b00);
            SZ_DWORD: aligned = (addr[2:0] == 3'b000);
            default:  aligned = 1'b0;
        endcase
        in_prio = (addr[OFFS_W-1:IDX_W] == OFF_PRIO[OFFS_W-1:IDX_W]);
    end

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            unique case (acc_size_e'(size))
                SZ_BYTE: if (in_prio) sel = SEL_PRIO;
                SZ_WORD: begin
                    case (addr)
                        OFF_CTRL:       sel = SEL_CTRL;
                        OFF_IDENT:      sel = SEL_IDENT;
                        OFF_TYPE:       sel = SEL_TYPE_LO;
                        OFF_TYPE + 4:   sel = SEL_TYPE_HI;
                        OFF_WAKE:       sel = SEL_WAKE;
                        OFF_PROP:       sel = SEL_PROP_LO;
                        OFF_PROP + 4:   sel = SEL_PROP_HI;
                        OFF_PNDB:       sel = SEL_PNDB_LO;
                        OFF_PNDB + 4:   sel = SEL_PNDB_HI;
                        OFF_GROUP:      sel = SEL_GROUP;
                        OFF_SEN:        sel = SEL_SEN;
                        OFF_CEN:        sel = SEL_CEN;
                        OFF_SPEND:      sel = SEL_SPEND;
                        OFF_CPEND:      sel = SEL_CPEND;
                        OFF_SACT:       sel = SEL_SACT;
                        OFF_CACT:       sel = SEL_CACT;
                        OFF_CFG0:       sel = SEL_CFG0;
                        OFF_CFG1:       sel = SEL_CFG1;
                        OFF_GMOD:       sel = SEL_GMOD;
                        OFF_NSAC:       sel = SEL_NSAC;
                        default:        if (in_prio) sel = SEL_PRIO;
                    endcase
                end
                SZ_DWORD: begin
                    case (addr)
                        OFF_TYPE: sel = SEL_TYPE64;
                        OFF_PROP: sel = SEL_PROP64;
                        OFF_PNDB: sel = SEL_PNDB64;
                        default:  sel = SEL_NONE;
                    endcase
                end
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/prv_irq_prio_bank.sv
module prv_irq_prio_bank
    import prv_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                word_mode,
    input  logic [IDX_W-1:0]    idx,
    input  logic [31:0]         wdata,
    input  logic                ns_view,
    input  logic [NIRQ-1:0]     group,
    output logic [31:0]         rd_data,
    output logic                changed
);
    localparam int LANES = 32 / PRIO_W;

    logic [PRIO_W-1:0] prio_q   [NIRQ];
    logic [PRIO_W-1:0] prio_nxt [NIRQ];
    logic [NIRQ-1:0]   we;

    always_comb begin
        changed = 1'b0;
        for (int i = 0; i < NIRQ; i++) begin
            logic [IDX_W-1:0] ii;
            logic [1:0]       lane;
            logic             hit;
            logic [PRIO_W-1:0] v;
            ii   = IDX_W'(i);
            hit  = word_mode ? (ii[IDX_W-1:2] == idx[IDX_W-1:2]) : (ii == idx);
            lane = word_mode ? ii[1:0] : 2'd0;
            v    = wdata[PRIO_W*lane +: PRIO_W];
            prio_nxt[i] = ns_view ? prio_ns_store(v) : v;
            we[i] = wr_en && hit && (!ns_view || group[i]);
            if (we[i] && (prio_nxt[i] != prio_q[i])) changed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NIRQ; i++) begin
            if (rst)        prio_q[i] <= '0;
            else if (we[i]) prio_q[i] <= prio_nxt[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            logic [IDX_W-1:0]  ridx;
            logic [PRIO_W-1:0] f;
            ridx = word_mode ? {idx[IDX_W-1:2], 2'(k)} : idx;
            f = prio_q[ridx];
            if (ns_view) f = group[ridx] ? prio_ns_view(f) : '0;
            if (word_mode || k == 0) rd_data[PRIO_W*k +: PRIO_W] = f;
        end
    end
endmodule

// File: rtl/prv_irq_regs.sv
module prv_irq_regs
    import prv_irq_pkg::*;
#(
    parameter logic [31:0] IDENT_VAL   = 32'h0003_1D4C,
    parameter logic [63:0] TYPE_VAL    = 64'h0000_0100_0000_0001,
    parameter bit          LPI_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_disable,
    input  logic [NIRQ-1:0]   irq_level,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_secure,
    input  logic [OFFS_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              update_pulse,
    output logic              rescan_req
);
    typedef struct packed {
        logic [NIRQ-1:0] group;
        logic [NIRQ-1:0] gmod;
        logic [NIRQ-1:0] en;
        logic [NIRQ-1:0] pend;
        logic [NIRQ-1:0] act;
        logic [NIRQ-1:0] edge_t;
        logic [31:0]     nsac;
        logic            sleep;
        logic            lpi_en;
        logic [63:0]     prop;
        logic [63:0]     pndb;
    } bank_t;

    bank_t    st_q, st_d;
    reg_sel_e sel;
    logic     wr, rd;
    logic     ns_restr, sec_only_ok;
    logic [NIRQ-1:0] amask;
    logic [31:0] w32;
    logic [31:0] prio_rd;
    logic        prio_chg;
    logic [63:0] rd_data;
    logic        rescan_d, update_d;

    assign wr          = req_valid && req_write;
    assign rd          = req_valid && !req_write;
    assign ns_restr    = !sec_disable && !req_secure;
    assign sec_only_ok = !sec_disable && req_secure;
    assign amask       = ns_restr ? st_q.group : '1;
    assign w32         = req_wdata[31:0];

    prv_irq_decode u_dec (
        .addr (req_addr),
        .size (req_size),
        .sel  (sel)
    );

    prv_irq_prio_bank u_prio (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr && sel == SEL_PRIO),
        .word_mode (req_size == SZ_WORD),
        .idx       (req_addr[IDX_W-1:0]),
        .wdata     (w32),
        .ns_view   (ns_restr),
        .group     (st_q.group),
        .rd_data   (prio_rd),
        .changed   (prio_chg)
    );

    // Write path
    always_comb begin
        logic [NIRQ-1:0] cm;
        st_d     = st_q;
        rescan_d = 1'b0;
        cm       = amask & 32'hFFFF_0000;
        if (wr) begin
            case (sel)
                SEL_CTRL: if (LPI_SUPPORT) begin
                    st_d.lpi_en = w32[0];
                    rescan_d    = w32[0];
                end
                SEL_WAKE:    st_d.sleep = w32[1];
                SEL_PROP_LO: st_d.prop[31:0]  = w32;
                SEL_PROP_HI: st_d.prop[63:32] = w32;
                SEL_PROP64:  st_d.prop        = req_wdata;
                SEL_PNDB_LO: st_d.pndb[31:0]  = w32;
                SEL_PNDB_HI: st_d.pndb[63:32] = w32;
                SEL_PNDB64:  st_d.pndb        = req_wdata;
                SEL_GROUP:   if (!ns_restr) st_d.group = w32;
                SEL_SEN:     st_d.en   = st_q.en   |  (w32 & amask);
                SEL_CEN:     st_d.en   = st_q.en   & ~(w32 & amask);
                SEL_SPEND:   st_d.pend = st_q.pend |  (w32 & amask);
                SEL_CPEND:   st_d.pend = st_q.pend & ~(w32 & amask);
                SEL_SACT:    st_d.act  = st_q.act  |  (w32 & amask);
                SEL_CACT:    st_d.act  = st_q.act  & ~(w32 & amask);
                SEL_CFG1:    st_d.edge_t = (st_q.edge_t & ~cm) |
                                           ({cfg_compact(w32), 16'h0000} & cm);
                SEL_GMOD:    if (sec_only_ok) st_d.gmod = w32;
                SEL_NSAC:    if (sec_only_ok) st_d.nsac = w32;
                default: ;
            endcase
        end
        update_d = wr && (prio_chg ||
                          st_d.group  != st_q.group ||
                          st_d.en     != st_q.en     ||
                          st_d.pend   != st_q.pend   ||
                          st_d.act    != st_q.act    ||
                          st_d.edge_t != st_q.edge_t);
    end

    // Read path
    always_comb begin
        logic [NIRQ-1:0] em;
        em      = st_q.edge_t & amask;
        rd_data = '0;
        case (sel)
            SEL_CTRL:    rd_data[0] = st_q.lpi_en;
            SEL_IDENT:   rd_data[31:0] = IDENT_VAL;
            SEL_TYPE_LO: rd_data[31:0] = TYPE_VAL[31:0];
            SEL_TYPE_HI: rd_data[31:0] = TYPE_VAL[63:32];
            SEL_TYPE64:  rd_data = TYPE_VAL;
            SEL_WAKE:    rd_data[2:1] = {st_q.sleep, st_q.sleep};
            SEL_PROP_LO: rd_data[31:0] = st_q.prop[31:0];
            SEL_PROP_HI: rd_data[31:0] = st_q.prop[63:32];
            SEL_PROP64:  rd_data = st_q.prop;
            SEL_PNDB_LO: rd_data[31:0] = st_q.pndb[31:0];
            SEL_PNDB_HI: rd_data[31:0] = st_q.pndb[63:32];
            SEL_PNDB64:  rd_data = st_q.pndb;
            SEL_GROUP:   rd_data[31:0] = ns_restr ? '0 : st_q.group;
            SEL_SEN, SEL_CEN:     rd_data[31:0] = st_q.en & amask;
            SEL_SPEND, SEL_CPEND: rd_data[31:0] =
                (st_q.pend | (irq_level & ~st_q.edge_t)) & amask;
            SEL_SACT, SEL_CACT:   rd_data[31:0] = st_q.act & amask;
            SEL_PRIO:    rd_data[31:0] = prio_rd;
            SEL_CFG0:    rd_data[31:0] = cfg_spread(em[15:0]);
            SEL_CFG1:    rd_data[31:0] = cfg_spread(em[31:16]);
            SEL_GMOD:    rd_data[31:0] = sec_only_ok ? st_q.gmod : '0;
            SEL_NSAC:    rd_data[31:0] = sec_only_ok ? st_q.nsac : '0;
            default:     rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.edge_t  <= EDGE_RESET;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            update_pulse <= 1'b0;
            rescan_req   <= 1'b0;
        end else begin
            st_q         <= st_d;
            rsp_valid    <= rd;
            rsp_rdata    <= rd ? rd_data : '0;
            update_pulse <= update_d;
            rescan_req   <= rescan_d;
        end
    end
endmodule

// File: rtl/prv_irq_regs_chk.sv
module prv_irq_regs_chk
    import prv_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_disable,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              req_secure,
    input logic [OFFS_W-1:0] req_addr,
    input logic [63:0]       req_wdata,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic              update_pulse,
    input logic              rescan_req
);
    a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    a_r13_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r11_rescan_from_ctrl: assert property (@(posedge clk) disable iff (rst)
        rescan_req |-> $past(req_valid && req_write && req_size == 2'd1 &&
                             req_addr == OFF_CTRL && req_wdata[0]));

    a_r12_update_after_write: assert property (@(posedge clk) disable iff (rst)
        update_pulse |-> $past(req_valid && req_write));

    a_r10_bad_size_raz: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd3) |=> rsp_rdata == 64'd0);

    a_r8_gmod_hidden: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd1 && req_addr == OFF_GMOD &&
         (!req_secure || sec_disable)) |=> rsp_rdata == 64'd0);

    a_r3_group_hidden_ns: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd1 && req_addr == OFF_GROUP &&
         !req_secure && !sec_disable) |=> rsp_rdata == 64'd0);
endmodule

bind prv_irq_regs prv_irq_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sec_disable  (sec_disable),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_size     (req_size),
    .req_secure   (req_secure),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .update_pulse (update_pulse),
    .rescan_req   (rescan_req)
);

// File: tb/prv_irq_regs_tb.sv
module prv_irq_regs_tb_top;
    localparam logic [31:0] IDV = 32'h0003_1D4C;
    localparam logic [63:0] TPV = 64'h0000_0100_0000_0001;
    localparam logic [1:0] B = 2'd0, W = 2'd1, D = 2'd2, X = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_disable = 1'b0;
    logic [31:0] irq_level = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [1:0]  req_size = 2'd1;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, update_pulse, rescan_req;
    logic [63:0] rsp_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    prv_irq_regs dut_i (
        .clk(clk), .rst(rst), .sec_disable(sec_disable), .irq_level(irq_level),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .update_pulse(update_pulse), .rescan_req(rescan_req)
    );

    // Monitor: compares each returned read against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                logic [63:0] e;
                string t;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R13 unexpected response act=%h exp=none", rsp_rdata);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rsp_rdata !== e) begin
                        fails++;
                        $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, input logic sec,
                      input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_secure = sec;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic sec,
                      input logic [63:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_secure = sec;
        req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", t, act, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_bit(rsp_valid, 1'b0, "R1 rsp_valid");
        chk_bit(update_pulse, 1'b0, "R1 update_pulse");
        chk_bit(rescan_req, 1'b0, "R1 rescan_req");
        rd(12'h080, W, 1, 64'h0, "R1 group reset");
        rd(12'hC00, W, 1, 64'hAAAA_AAAA, "R1 cfg0 reset");
        rd(12'hC04, W, 1, 64'h0, "R1 cfg1 reset");
        rd(12'h014, W, 1, 64'h0, "R1 wake reset");
        rd(12'h410, W, 1, 64'h0, "R1 prio reset");
        rd(12'h004, W, 1, {32'h0, IDV}, "R10 ident");

        // R8 / R12 group write
        wr(12'h080, W, 1, 64'hFFFF_0000);
        chk_bit(update_pulse, 1'b1, "R12 group change");
        // R2 set/clear
        wr(12'h100, W, 1, 64'hFF);
        rd(12'h100, W, 1, 64'hFF, "R2 set enable");
        rd(12'h180, W, 1, 64'hFF, "R2 clear addr same reg");
        wr(12'h180, W, 1, 64'h0F);
        rd(12'h100, W, 1, 64'hF0, "R2 clear enable");
        wr(12'h100, W, 1, 64'hF0);
        chk_bit(update_pulse, 1'b0, "R12 no change no pulse");
        // R3 mask
        wr(12'h100, W, 0, 64'hFFFF_FFFF);
        rd(12'h100, W, 0, 64'hFFFF_0000, "R3 ns enable view");
        rd(12'h180, W, 1, 64'hFFFF_00F0, "R3 ns write masked");
        rd(12'h080, W, 0, 64'h0, "R8 group ns raz");
        wr(12'h080, W, 0, 64'h0);
        chk_bit(update_pulse, 1'b0, "R12 ignored write");
        rd(12'h080, W, 1, 64'hFFFF_0000, "R8 group ns wi");

        // R4 / R5 priorities
        wr(12'h410, W, 1, 64'h4433_2211);
        chk_bit(update_pulse, 1'b1, "R12 prio change");
        rd(12'h410, W, 1, 64'h4433_2211, "R5 word pack");
        rd(12'h410, W, 0, 64'h8866_4422, "R4 ns view");
        wr(12'h411, B, 0, 64'h40);
        rd(12'h411, B, 1, 64'hA0, "R4 ns store");
        rd(12'h411, B, 0, 64'h40, "R4 ns byte read");
        wr(12'h400, W, 1, 64'h0102_0304);
        rd(12'h400, W, 0, 64'h0, "R4 group0 raz");
        wr(12'h400, W, 0, 64'hFFFF_FFFF);
        chk_bit(update_pulse, 1'b0, "R12 prio ignored");
        rd(12'h400, W, 1, 64'h0102_0304, "R4 group0 wi");
        rd(12'h402, B, 1, 64'h02, "R5 byte lane");

        // R6 / R7 pending and trigger
        irq_level = 32'h0003_0000;
        rd(12'h200, W, 1, 64'h0003_0000, "R6 level pending");
        wr(12'hC04, W, 1, 64'h2);
        chk_bit(update_pulse, 1'b1, "R12 trigger change");
        rd(12'h200, W, 1, 64'h0002_0000, "R6 edge hides level");
        rd(12'hC04, W, 1, 64'h2, "R7 cfg1 read");
        wr(12'hC00, W, 1, 64'h0);
        rd(12'hC00, W, 1, 64'hAAAA_AAAA, "R7 cfg0 wi");
        wr(12'h200, W, 1, 64'h1);
        rd(12'h280, W, 1, 64'h0002_0001, "R6 latch or level");
        wr(12'h280, W, 1, 64'h1);
        rd(12'h200, W, 1, 64'h0002_0000, "R2 clear pending");
        wr(12'hC04, W, 0, 64'hFFFF_FFFF);
        rd(12'hC04, W, 1, 64'hAAAA_AAAA, "R7 ns cfg1 write");
        rd(12'hC00, W, 0, 64'h0, "R7 ns cfg0 masked");
        rd(12'h200, W, 1, 64'h0, "R6 all edge");
        wr(12'h300, W, 1, 64'h8000_0001);
        rd(12'h380, W, 1, 64'h8000_0001, "R2 set active");
        wr(12'h380, W, 0, 64'hFFFF_FFFF);
        rd(12'h300, W, 1, 64'h1, "R3 ns clear active");

        // R8 secure-only registers
        wr(12'hD00, W, 1, 64'h5);
        rd(12'hD00, W, 1, 64'h5, "R8 gmod secure");
        rd(12'hD00, W, 0, 64'h0, "R8 gmod ns");
        wr(12'hE00, W, 0, 64'hFFFF);
        rd(12'hE00, W, 1, 64'h0, "R8 nsac ns wi");
        wr(12'hE00, W, 1, 64'h3);
        rd(12'hE00, W, 1, 64'h3, "R8 nsac secure");
        sec_disable = 1;
        rd(12'hD00, W, 1, 64'h0, "R8 gmod sec disabled");
        wr(12'hD00, W, 1, 64'h0);
        rd(12'h080, W, 0, 64'hFFFF_0000, "R3 ns full when disabled");
        rd(12'h400, W, 0, 64'h0102_0304, "R4 raw when disabled");
        wr(12'h400, B, 0, 64'h7F);
        rd(12'h400, B, 1, 64'h7F, "R4 raw store");
        sec_disable = 0;
        rd(12'hD00, W, 1, 64'h5, "R8 gmod kept");

        // R9 wake
        wr(12'h014, W, 1, 64'h2);
        rd(12'h014, W, 1, 64'h6, "R9 sleep");
        wr(12'h014, W, 1, 64'hFFFF_FFFF);
        rd(12'h014, W, 1, 64'h6, "R9 only sleep bit");
        wr(12'h014, W, 1, 64'h4);
        rd(12'h014, W, 1, 64'h0, "R9 wake");

        // R10 decode holes
        rd(12'h010, W, 1, 64'h0, "R10 unmapped");
        wr(12'h004, W, 1, 64'h0);
        rd(12'h004, W, 1, {32'h0, IDV}, "R10 ident ro");
        wr(12'h008, W, 1, 64'h0);
        rd(12'h008, W, 1, {32'h0, TPV[31:0]}, "R10 type lo ro");
        rd(12'h00C, W, 1, {32'h0, TPV[63:32]}, "R10 type hi");
        rd(12'h008, D, 1, TPV, "R10 type dword");
        rd(12'h080, X, 1, 64'h0, "R10 bad size");
        rd(12'h080, B, 1, 64'h0, "R10 byte outside prio");
        rd(12'h412, W, 1, 64'h0, "R10 misaligned");
        wr(12'h080, X, 1, 64'h0);
        rd(12'h080, W, 1, 64'hFFFF_0000, "R10 bad size wi");

        // R11 base registers and control
        wr(12'h070, D, 1, 64'h1122_3344_5566_7788);
        rd(12'h070, D, 1, 64'h1122_3344_5566_7788, "R11 prop dword");
        wr(12'h074, W, 1, 64'hAABB_CCDD);
        rd(12'h070, W, 1, 64'h5566_7788, "R11 prop lo");
        rd(12'h074, W, 1, 64'hAABB_CCDD, "R11 prop hi");
        rd(12'h070, D, 1, 64'hAABB_CCDD_5566_7788, "R11 prop merged");
        wr(12'h078, W, 1, 64'h1234_5678);
        rd(12'h078, D, 1, 64'h0000_0000_1234_5678, "R11 pend base");
        wr(12'h000, W, 1, 64'hFFFF_FFFF);
        chk_bit(rescan_req, 1'b1, "R11 rescan pulse");
        chk_bit(update_pulse, 1'b0, "R12 ctrl no update");
        rd(12'h000, W, 1, 64'h1, "R11 ctrl bit");
        chk_bit(rescan_req, 1'b0, "R11 rescan one cycle");
        wr(12'h000, W, 1, 64'h0);
        chk_bit(rescan_req, 1'b0, "R11 no rescan on clear");
        rd(12'h000, W, 1, 64'h0, "R11 ctrl cleared");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R13 missing responses act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule